// File: doc/BRIEF.md
# Staged Power-Up Reset Sequencer

The block turns one asynchronous active-low reset into three active-low reset outputs, and releases them one after another on a free-running system clock. The incoming reset first passes through a two-flop synchroniser. The synchronised reset goes out directly as the reset for the first Ethernet PHY. The second PHY reset follows a short, fixed number of cycles later, so the two PHYs never leave reset on the same clock edge. The reset for the main logic is held much longer, which gives both PHYs time to latch their strap pins after power-up.

With a 50 MHz clock, the default offset of 100 cycles is about 2 µs. The default core hold of 10,000,000 cycles is about 200 ms, which is more than a 167 ms strap-latch minimum. Both delays are parameters, so a simulation can use short values. All three outputs go low as soon as the input reset goes low, with or without a clock edge. Release always happens on a clock edge. When the input reset returns during a sequence, the sequence starts again from the beginning.

Top module: `pwrup_reset_seq`

## Requirements
- R1: While `arstN` is low, `phyAResetN`, `phyBResetN` and `coreResetN` are all 0. They fall as soon as `arstN` falls, without waiting for a clock edge.
- R2: `phyAResetN` rises on the second rising clock edge after `arstN` rises (two-stage synchroniser).
- R3: `phyBResetN` rises exactly `PHYB_DELAY` rising edges after the edge on which `phyAResetN` rose.
- R4: `coreResetN` rises exactly `CORE_DELAY` rising edges after the edge on which `phyAResetN` rose.
- R5: Once an output has risen, it stays at 1 for as long as `arstN` stays high.
- R6: If `arstN` goes low at any point in a sequence, including inside the synchroniser or during either delay, the next release of `arstN` repeats the whole sequence with the full timing of R2 to R4.
- R7: Neither `phyBResetN` nor `coreResetN` is ever 1 while `phyAResetN` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| arstN | input | 1 | Asynchronous reset request, active low |
| phyAResetN | output | 1 | Synchronised reset, also the first PHY reset, active low |
| phyBResetN | output | 1 | Second PHY reset, active low, released `PHYB_DELAY` cycles after the first |
| coreResetN | output | 1 | Main logic reset, active low, released `CORE_DELAY` cycles after the first |

## Verification
The checker enforces the following on every clock edge:
- all outputs are low while the reset request is low;
- the release order is kept;
- released outputs stay high;
- each rise of the second PHY reset or the core reset happens after the exact number of edges since the first PHY reset rose, which the checker counts itself.

Some behaviour shows only in the bench's scenarios:
- the outputs fall between clock edges;
- the two-edge synchroniser latency, measured from the input pin;
- the full timing is repeated after an abort inside the synchroniser;
- the full timing is repeated after an abort partway through the core hold.

// File: rtl/pwrup_reset_pkg.sv
package pwrup_reset_pkg;

  // Release strobes from the delay control to the output registers.
  typedef struct packed {
    logic releasePhyB;
    logic releaseCore;
  } relStrobe_t;

endpackage

// File: rtl/reset_sync_chain.sv
module reset_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  output logic syncRstN
);
  logic [STAGES-1:0] chain;

  // Low goes through at once; a release shifts in a 1 on each clock.
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign syncRstN = chain[STAGES-1];
endmodule

// File: rtl/reset_delay_ctrl.sv
module reset_delay_ctrl
  import pwrup_reset_pkg::*;
#(
  parameter int PHYB_DELAY = 100,
  parameter int CORE_DELAY = 10_000_000
) (
  input  logic       clk,
  input  logic       arstN,
  input  logic       syncRstN,
  output relStrobe_t strobe
);
  localparam int MAX_DELAY = (PHYB_DELAY > CORE_DELAY) ? PHYB_DELAY : CORE_DELAY;
  localparam int CNT_W     = (MAX_DELAY > 1) ? $clog2(MAX_DELAY + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST   = CNT_W'(MAX_DELAY - 1);
  localparam logic [CNT_W-1:0] PHYB_MATCH = CNT_W'(PHYB_DELAY - 1);
  localparam logic [CNT_W-1:0] CORE_MATCH = CNT_W'(CORE_DELAY - 1);

  logic [CNT_W-1:0] cycleCnt;

  // Counts the cycles since the synchronised release and saturates,
  // so the strobes stay high once reached.
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)               cycleCnt <= '0;
    else if (!syncRstN)       cycleCnt <= '0;
    else if (cycleCnt != CNT_LAST) cycleCnt <= cycleCnt + 1'b1;
  end

  always_comb begin
    strobe.releasePhyB = syncRstN && (cycleCnt >= PHYB_MATCH);
    strobe.releaseCore = syncRstN && (cycleCnt >= CORE_MATCH);
  end
endmodule

// File: rtl/reset_out_regs.sv
module reset_out_regs
  import pwrup_reset_pkg::*;
(
  input  logic       clk,
  input  logic       arstN,
  input  relStrobe_t strobe,
  output logic       phyBResetN,
  output logic       coreResetN
);
  // Asynchronous clear; the release is taken from the strobe on a clock edge.
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      phyBResetN <= 1'b0;
      coreResetN <= 1'b0;
    end else begin
      phyBResetN <= strobe.releasePhyB;
      coreResetN <= strobe.releaseCore;
    end
  end
endmodule

// File: rtl/pwrup_reset_seq.sv
module pwrup_reset_seq
  import pwrup_reset_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PHYB_DELAY  = 100,
  parameter int CORE_DELAY  = 10_000_000
) (
  input  logic clk,
  input  logic arstN,
  output logic phyAResetN,
  output logic phyBResetN,
  output logic coreResetN
);
  logic       syncRstN;
  relStrobe_t strobe;

  reset_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .arstN    (arstN),
    .syncRstN (syncRstN)
  );

  reset_delay_ctrl #(.PHYB_DELAY(PHYB_DELAY), .CORE_DELAY(CORE_DELAY)) u_ctrl (
    .clk      (clk),
    .arstN    (arstN),
    .syncRstN (syncRstN),
    .strobe   (strobe)
  );

  reset_out_regs u_regs (
    .clk        (clk),
    .arstN      (arstN),
    .strobe     (strobe),
    .phyBResetN (phyBResetN),
    .coreResetN (coreResetN)
  );

  assign phyAResetN = syncRstN;
endmodule

// File: rtl/pwrup_reset_seq_chk.sv
module pwrup_reset_seq_chk #(
  parameter int PHYB_DELAY = 100,
  parameter int CORE_DELAY = 10_000_000
) (
  input logic clk,
  input logic arstN,
  input logic phyAResetN,
  input logic phyBResetN,
  input logic coreResetN
);
  localparam int MAXD = (PHYB_DELAY > CORE_DELAY) ? PHYB_DELAY : CORE_DELAY;
  localparam int CW   = $clog2(MAXD + 2);
  localparam logic [CW-1:0] SAT = CW'(MAXD + 1);

  // Edges counted while phyAResetN was high.
  logic [CW-1:0] sinceA;
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)                          sinceA <= '0;
    else if (phyAResetN && sinceA != SAT) sinceA <= sinceA + 1'b1;
  end

  // R1
  rst_low_chk: assert property (@(posedge clk)
    !arstN |-> (!phyAResetN && !phyBResetN && !coreResetN));

  // R7
  order_phyb_chk: assert property (@(posedge clk) disable iff (!arstN)
    phyBResetN |-> phyAResetN);

  // R7
  order_core_chk: assert property (@(posedge clk) disable iff (!arstN)
    coreResetN |-> phyAResetN);

  // R5
  hold_phya_chk: assert property (@(posedge clk) disable iff (!arstN)
    phyAResetN |=> phyAResetN);

  // R5
  hold_phyb_chk: assert property (@(posedge clk) disable iff (!arstN)
    phyBResetN |=> phyBResetN);

  // R5
  hold_core_chk: assert property (@(posedge clk) disable iff (!arstN)
    coreResetN |=> coreResetN);

  // R3
  phyb_delay_chk: assert property (@(posedge clk) disable iff (!arstN)
    $rose(phyBResetN) |-> (sinceA == CW'(PHYB_DELAY)));

  // R4
  core_delay_chk: assert property (@(posedge clk) disable iff (!arstN)
    $rose(coreResetN) |-> (sinceA == CW'(CORE_DELAY)));
endmodule

bind pwrup_reset_seq pwrup_reset_seq_chk #(
  .PHYB_DELAY (PHYB_DELAY),
  .CORE_DELAY (CORE_DELAY)
) u_chk (
  .clk        (clk),
  .arstN      (arstN),
  .phyAResetN (phyAResetN),
  .phyBResetN (phyBResetN),
  .coreResetN (coreResetN)
);

// File: tb/pwrup_reset_seq_bench.sv
`timescale 1ns/1ps
module pwrup_reset_seq_bench;
  localparam int N = 100;
  localparam int M = 1000;

  logic clk = 1'b0;
  logic arstN;
  logic phyAResetN, phyBResetN, coreResetN;
  int   checks = 0;
  int   errors = 0;

  always #4 clk = ~clk;

  pwrup_reset_seq #(.SYNC_STAGES(2), .PHYB_DELAY(N), .CORE_DELAY(M)) u_pwrup_reset_seq (
    .clk        (clk),
    .arstN      (arstN),
    .phyAResetN (phyAResetN),
    .phyBResetN (phyBResetN),
    .coreResetN (coreResetN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {29'd0, phyAResetN, phyBResetN, coreResetN};
  endfunction

  // Releases arstN at a falling edge and records the falling-edge sample index
  // at which each output first reads 1.
  task automatic run_sequence(input string tag);
    int kA = -1, kB = -1, kC = -1;
    bit fell = 0, badOrder = 0;
    @(negedge clk);
    arstN = 1'b1;
    for (int k = 1; k <= M + 20; k++) begin
      @(negedge clk);
      if (phyAResetN && kA < 0) kA = k;
      if (phyBResetN && kB < 0) kB = k;
      if (coreResetN && kC < 0) kC = k;
      if ((kA > 0 && !phyAResetN) || (kB > 0 && !phyBResetN) || (kC > 0 && !coreResetN)) fell = 1;
      if ((phyBResetN || coreResetN) && !phyAResetN) badOrder = 1;
    end
    check(kA == 2, {"R2 phyA latency ", tag}, kA, 2);
    check(kB - kA == N, {"R3 phyB offset ", tag}, kB - kA, N);
    check(kC - kA == M, {"R4 core offset ", tag}, kC - kA, M);
    check(!badOrder, {"R7 release order ", tag}, badOrder, 0);
    check(!fell, {"R5 outputs held ", tag}, fell, 0);
  endtask

  task automatic t_reset_state();
    repeat (5) @(negedge clk);
    check(outs() == 0, "R1 all low in reset", outs(), 0);
  endtask

  task automatic t_first_sequence();
    run_sequence("first");
  endtask

  // Abort after phyB released, inside the core hold.
  task automatic t_abort_late();
    @(negedge clk);
    arstN = 1'b0;
    repeat (3) @(negedge clk);
    arstN = 1'b1;
    repeat (N + 20) @(negedge clk);
    check(phyBResetN && !coreResetN, "R6 mid-core state before abort",
          outs(), 3'b110);
    #2 arstN = 1'b0;
    #1 check(outs() == 0, "R1 async fall without edge", outs(), 0);
    repeat (3) @(negedge clk);
    check(outs() == 0, "R1 held low", outs(), 0);
    run_sequence("r6_after_late_abort");
  endtask

  // Abort while the release is still inside the synchroniser.
  task automatic t_abort_early();
    @(negedge clk);
    arstN = 1'b0;
    repeat (2) @(negedge clk);
    arstN = 1'b1;
    @(negedge clk);
    check(outs() == 0, "R6 still in synchroniser", outs(), 0);
    arstN = 1'b0;
    repeat (2) @(negedge clk);
    run_sequence("r6_after_early_abort");
  endtask

  initial begin
    arstN = 1'b1;
    #2 arstN = 1'b0;
    t_reset_state();
    t_first_sequence();
    t_abort_late();
    t_abort_early();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule